// File: doc/BRIEF.md
# Timing Reference Selector

This block decides which timing reference steers a clock generator's phase-locked loop, and when the loop must stop following any reference and coast. It runs in one of two modes. In external mode it follows a primary and a secondary external reference. In line-timed mode it follows a primary and a secondary line-derived reference. If both line references are lost, it falls back to the primary external reference, but only when that input is fitted.

Each reference has a raw valid flag. The block trusts a reference only after the flag has stayed high for a programmable number of sample ticks. A reference is dropped on the first cycle its flag goes low. The selection is revertive: the most preferred trusted reference always wins. When nothing usable remains, the block enters holdover. In holdover it presents a frozen copy of the loop's frequency control word, taken on the last tick on which the selected reference was still trusted.

A local out-of-tolerance indication makes the block suppress its timing outputs and raise a fault flag toward the shelf controller.

Top module: `tref_selector`

## Requirements
- R1: After reset, `holdover_o` is 1, `hold_word_o` is 0, `ref_sel_o` is 2'b00, and `suppress_o` and `fault_o` are 0.
- R2: A reference is usable only after its valid flag has been high at `qual_len_i` rising edges on which `tick_i` was also high, counted without a gap. The flag going low clears the count at once and makes the reference unusable in that same cycle. A `qual_len_i` of 0 makes the reference usable as soon as its flag is high.
- R3: With `mode_line_i` = 0, the primary external reference is chosen whenever it is usable. Otherwise the secondary external reference is chosen if it is usable.
- R4: With `mode_line_i` = 0 and neither external reference usable, `holdover_o` is 1. Line references are never chosen in this mode.
- R5: With `mode_line_i` = 1, the primary line reference is chosen whenever it is usable. Otherwise the secondary line reference is chosen if it is usable.
- R6: With `mode_line_i` = 1 and neither line reference usable, the primary external reference is chosen if `ext_pri_equip_i` is 1 and that reference is usable.
- R7: With `mode_line_i` = 1 and no permitted reference usable, `holdover_o` is 1. This includes the case where `ext_pri_equip_i` is 0.
- R8: Selection is revertive. When a more preferred reference becomes usable again, the block returns to it at the next edge.
- R9: `hold_word_o` takes `loop_word_i` at every edge where `tick_i` is 1, `holdover_o` is 0 and the currently selected reference is usable. At all other edges it keeps its value, so it is frozen throughout holdover.
- R10: `suppress_o` and `fault_o` follow `oot_i` with one cycle of delay.
- R11: The select code is 2'b00 for primary external, 2'b01 for secondary external, 2'b10 for primary line and 2'b11 for secondary line. All outputs are registered one edge after the inputs that decide them. While `holdover_o` is 1, `ref_sel_o` is not meaningful and keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sample tick enable |
| mode_line_i | input | 1 | 0 = external mode, 1 = line-timed mode |
| ext_pri_ok_i | input | 1 | Primary external reference valid |
| ext_sec_ok_i | input | 1 | Secondary external reference valid |
| line_pri_ok_i | input | 1 | Primary line reference valid |
| line_sec_ok_i | input | 1 | Secondary line reference valid |
| ext_pri_equip_i | input | 1 | Primary external reference is fitted |
| qual_len_i | input | QUAL_W | Ticks needed to trust a reference |
| oot_i | input | 1 | Local clock out of tolerance |
| loop_word_i | input | CW_W | Current loop frequency control word |
| ref_sel_o | output | 2 | Selected reference code |
| holdover_o | output | 1 | Holdover active |
| hold_word_o | output | CW_W | Last good control word |
| suppress_o | output | 1 | Suppress timing outputs |
| fault_o | output | 1 | Fault toward controller |

## Verification
The hardest state to reach is in line-timed mode. Both line references have failed, the fitted primary external reference carries the loop, and then a line reference recovers and must win back after a full qualification run. Directed sequences build that chain step by step under a fixed qualification length. They also cover the same chain with the external input not fitted, and the frozen word across a holdover gap. A long random phase then flips valid flags rarely enough for qualification to complete. In that phase, ticks, mode, fitting and tolerance change under a cycle-accurate model in the bench.

// File: rtl/tref_pkg.sv
package tref_pkg;
    localparam int NUM_REFS = 4;

    typedef enum logic [1:0] {
        SEL_EXT_PRI  = 2'b00,
        SEL_EXT_SEC  = 2'b01,
        SEL_LINE_PRI = 2'b10,
        SEL_LINE_SEC = 2'b11
    } ref_code_e;
endpackage

// File: rtl/tref_qual.sv
module tref_qual #(
    parameter int QUAL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              valid_i,
    input  logic [QUAL_W-1:0] len_i,
    output logic              qual_o
);
    logic [QUAL_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!valid_i) begin
            cnt_d = '0;
        end else if (tick_i && (cnt_q < len_i)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign qual_o = valid_i && (cnt_q >= len_i);

    // R2
    qual_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(qual_o) && (len_i != '0)) |-> $past(valid_i));
endmodule

// File: rtl/tref_pick.sv
module tref_pick
    import tref_pkg::*;
(
    input  logic                mode_line_i,
    input  logic                equip_i,
    input  logic [NUM_REFS-1:0] qual_i,
    output ref_code_e           code_o,
    output logic                none_o
);
    always_comb begin
        code_o = SEL_EXT_PRI;
        none_o = 1'b0;
        if (!mode_line_i) begin
            if (qual_i[SEL_EXT_PRI])      code_o = SEL_EXT_PRI;
            else if (qual_i[SEL_EXT_SEC]) code_o = SEL_EXT_SEC;
            else                          none_o = 1'b1;
        end else begin
            if (qual_i[SEL_LINE_PRI])                 code_o = SEL_LINE_PRI;
            else if (qual_i[SEL_LINE_SEC])            code_o = SEL_LINE_SEC;
            else if (equip_i && qual_i[SEL_EXT_PRI])  code_o = SEL_EXT_PRI;
            else                                      none_o = 1'b1;
        end
    end
endmodule

// File: rtl/tref_selector.sv
module tref_selector
    import tref_pkg::*;
#(
    parameter int CW_W   = 16,
    parameter int QUAL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              mode_line_i,
    input  logic              ext_pri_ok_i,
    input  logic              ext_sec_ok_i,
    input  logic              line_pri_ok_i,
    input  logic              line_sec_ok_i,
    input  logic              ext_pri_equip_i,
    input  logic [QUAL_W-1:0] qual_len_i,
    input  logic              oot_i,
    input  logic [CW_W-1:0]   loop_word_i,
    output logic [1:0]        ref_sel_o,
    output logic              holdover_o,
    output logic [CW_W-1:0]   hold_word_o,
    output logic              suppress_o,
    output logic              fault_o
);
    typedef struct packed {
        ref_code_e       sel;
        logic            hold;
        logic [CW_W-1:0] track;
        logic            supp;
        logic            fault;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_REFS-1:0] valid_vec;
    logic [NUM_REFS-1:0] qual;
    ref_code_e           pick_code;
    logic                pick_none;

    assign valid_vec = {line_sec_ok_i, line_pri_ok_i, ext_sec_ok_i, ext_pri_ok_i};

    for (genvar gi = 0; gi < NUM_REFS; gi++) begin : g_qual
        tref_qual #(.QUAL_W(QUAL_W)) u_qual (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick_i),
            .valid_i (valid_vec[gi]),
            .len_i   (qual_len_i),
            .qual_o  (qual[gi])
        );
    end

    tref_pick u_pick (
        .mode_line_i (mode_line_i),
        .equip_i     (ext_pri_equip_i),
        .qual_i      (qual),
        .code_o      (pick_code),
        .none_o      (pick_none)
    );

    always_comb begin
        st_d       = st_q;
        st_d.hold  = pick_none;
        if (!pick_none) st_d.sel = pick_code;
        if (tick_i && !st_q.hold && qual[st_q.sel]) st_d.track = loop_word_i;
        st_d.supp  = oot_i;
        st_d.fault = oot_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel   <= SEL_EXT_PRI;
            st_q.hold  <= 1'b1;
            st_q.track <= '0;
            st_q.supp  <= 1'b0;
            st_q.fault <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_sel_o   = st_q.sel;
    assign holdover_o  = st_q.hold;
    assign hold_word_o = st_q.track;
    assign suppress_o  = st_q.supp;
    assign fault_o     = st_q.fault;

    // R9
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        holdover_o |=> $stable(hold_word_o));
    // R10
    oot_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oot_i |=> (suppress_o && fault_o));
    // R4
    ext_no_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_line_i |=> (holdover_o || !ref_sel_o[1]));
    // R3
    ext_pri_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_line_i && qual[0]) |=> (!holdover_o && ref_sel_o == 2'b00));
    // R5
    line_pri_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_line_i && qual[2]) |=> (!holdover_o && ref_sel_o == 2'b10));
    // R7
    line_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_line_i && !ext_pri_equip_i && !qual[2] && !qual[3]) |=> holdover_o);
endmodule

// File: tb/tref_selector_test.sv
module tref_selector_test;
    localparam int CW_W   = 16;
    localparam int QUAL_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              mode_line = 1'b0;
    logic [3:0]        vld = 4'b0000;
    logic              equip = 1'b0;
    logic [QUAL_W-1:0] qlen = '0;
    logic              oot = 1'b0;
    logic [CW_W-1:0]   lword = '0;
    logic [1:0]        ref_sel;
    logic              holdover;
    logic [CW_W-1:0]   hold_word;
    logic              suppress;
    logic              fault;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int          m_cnt [4];
    logic [1:0]  m_sel = 2'b00;
    logic        m_hold = 1'b1;
    logic [CW_W-1:0] m_track = '0;
    logic        m_supp = 1'b0;

    always #5 clk = ~clk;

    tref_selector #(.CW_W(CW_W), .QUAL_W(QUAL_W)) uut (
        .clk (clk), .rst_n (rst_n), .tick_i (tick), .mode_line_i (mode_line),
        .ext_pri_ok_i (vld[0]), .ext_sec_ok_i (vld[1]),
        .line_pri_ok_i (vld[2]), .line_sec_ok_i (vld[3]),
        .ext_pri_equip_i (equip), .qual_len_i (qlen), .oot_i (oot),
        .loop_word_i (lword), .ref_sel_o (ref_sel), .holdover_o (holdover),
        .hold_word_o (hold_word), .suppress_o (suppress), .fault_o (fault)
    );

    function automatic string sel_tag(logic ml, logic h, logic [1:0] s);
        if (!ml) return h ? "R4" : "R3";
        if (h) return "R7";
        if (s == 2'b00) return "R6";
        return "R5";
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic model_edge();
        logic [3:0] q;
        logic [1:0] nsel;
        logic       nhold;
        for (int i = 0; i < 4; i++) q[i] = vld[i] && (m_cnt[i] >= int'(qlen));
        nhold = 1'b0;
        nsel  = m_sel;
        if (!mode_line) begin
            if (q[0]) nsel = 2'b00;
            else if (q[1]) nsel = 2'b01;
            else nhold = 1'b1;
        end else begin
            if (q[2]) nsel = 2'b10;
            else if (q[3]) nsel = 2'b11;
            else if (equip && q[0]) nsel = 2'b00;
            else nhold = 1'b1;
        end
        if (tick && !m_hold && q[m_sel]) m_track = lword;
        m_sel  = nsel;
        m_hold = nhold;
        m_supp = oot;
        for (int i = 0; i < 4; i++) begin
            if (!vld[i]) m_cnt[i] = 0;
            else if (tick && m_cnt[i] < int'(qlen)) m_cnt[i]++;
        end
    endtask

    // advance one edge, update model, compare all outputs
    task automatic step();
        @(posedge clk);
        cycles++;
        model_edge();
        #2;
        chk({sel_tag(mode_line, m_hold, m_sel), " holdover"}, int'(holdover), int'(m_hold));
        if (!m_hold) chk({sel_tag(mode_line, m_hold, m_sel), " R8 R11 ref_sel"}, int'(ref_sel), int'(m_sel));
        chk("R9 hold_word", int'(hold_word), int'(m_track));
        chk("R10 suppress", int'(suppress), int'(m_supp));
        chk("R10 fault", int'(fault), int'(m_supp));
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            lword = CW_W'($urandom);
            step();
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk("R1 holdover", int'(holdover), 1);
        chk("R1 hold_word", int'(hold_word), 0);
        chk("R1 ref_sel", int'(ref_sel), 0);
        chk("R1 suppress", int'(suppress), 0);
        chk("R1 fault", int'(fault), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 qualification length 3 on primary external
        qlen = 8'd3; tick = 1'b1; vld = 4'b0001;
        run(3);
        chk("R2 still holdover after 3 ticks", int'(holdover), 1);
        run(1);
        chk("R2 qualified after 4th edge", int'(holdover), 0);
        chk("R11 code ext primary", int'(ref_sel), 0);
        // R3 secondary takes over, R8 primary reverts after requal
        vld = 4'b0010; run(6);
        chk("R3 secondary external", int'(ref_sel), 1);
        vld = 4'b0011; run(6);
        chk("R8 revert to primary external", int'(ref_sel), 0);
        // R4 both fail, R9 frozen word
        vld = 4'b1100; run(1);
        chk("R4 holdover when externals fail", int'(holdover), 1);
        run(5);
        // R5 line mode
        mode_line = 1'b1; run(2);
        chk("R5 line primary", int'(ref_sel), 2);
        vld = 4'b1000; run(1);
        chk("R5 line secondary", int'(ref_sel), 3);
        // R6 fallback to fitted external primary
        vld = 4'b0001; equip = 1'b1; run(5);
        chk("R6 fallback ext primary", int'(ref_sel), 0);
        equip = 1'b0; run(1);
        chk("R7 unfitted external forces holdover", int'(holdover), 1);
        equip = 1'b1; vld = 4'b0101; run(5);
        chk("R8 line primary reclaims", int'(ref_sel), 2);
        // R2 zero length
        qlen = '0; vld = 4'b0000; run(1); vld = 4'b0010; mode_line = 1'b0; run(1);
        chk("R2 zero length immediate", int'(ref_sel), 1);
        // R10
        oot = 1'b1; run(2); oot = 1'b0; run(2);

        // random phase
        qlen = 8'd2;
        for (int n = 0; n < 4000; n++) begin
            tick = ($urandom_range(3, 0) != 0);
            for (int i = 0; i < 4; i++)
                if ($urandom_range(15, 0) == 0) vld[i] = ~vld[i];
            if ($urandom_range(199, 0) == 0) mode_line = ~mode_line;
            if ($urandom_range(99, 0) == 0) equip = ~equip;
            if ($urandom_range(49, 0) == 0) oot = ~oot;
            if ($urandom_range(299, 0) == 0) qlen = QUAL_W'($urandom_range(4, 0));
            run(1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule